// File: doc/BRIEF.md
# Interrupt Thread Context Presenter

This block keeps the interrupt context of a small array of hardware threads and finds the thread that should receive an interrupt. Each thread has four register rings, numbered 0 to 3: physical, hypervisor, OS and user. Every ring holds an 8-bit pending buffer, a current processor priority (CPPR), a 24-bit CAM line with a valid bit, and a pending-priority value. The pending-priority value is always derived from the buffer and cannot be written. The physical ring's CAM line is fixed. It is built from the chip number and the thread number, so software can only change its valid bit.

Software reaches the rings through a register-access port that supports read, write and pull. A pull returns a ring's CAM word and clears its valid bit in the same access. The interrupt router uses a delivery port: it presents a 24-bit target and a priority from 0 to 7. The block compares the target with every valid CAM line and sets the priority bit in the matching ring's buffer. When nothing matches, it reports a one-cycle no-match pulse. Each thread drives an exception output for as long as one of its rings holds a pending priority more favoured than that ring's CPPR. Priority 0 is the most favoured.

Top module: `ctx_presenter`

## Requirements
- R1: After reset, every pending buffer and CPPR is 0 and the CAM lines of rings 1 to 3 are invalid. The physical ring's CAM line is valid. `exc_out`, `dlv_miss` and `acc_rvalid` are 0.
- R2: The physical ring's CAM word reads bit 31 = valid, bits 23:19 = `CHIP_ID`, bits 18:11 = 0, bits 10:7 = 4'b0001 and bits 6:0 = the thread number. A CAM write to ring 0 changes only the valid bit.
- R3: Field 1 (pending priority) reads the index of the lowest set bit of the pending buffer, or 0xFF when the buffer is empty. Writes to field 1 change nothing.
- R4: A pull (`acc_op`=2) returns the ring's CAM word as it was before the access and clears that ring's valid bit. The CAM bits are kept.
- R5: A delivery whose target equals a valid CAM line sets bit `dlv_prio` in that ring's pending buffer. The change is visible to a read issued in any later cycle.
- R6: When several lines match, the lowest-numbered thread wins. Within one thread, the lowest ring number wins. Only that one ring is updated.
- R7: A CAM line whose valid bit is clear never matches.
- R8: A delivery with no match raises `dlv_miss` for exactly the next cycle and changes no state.
- R9: `exc_out[t]` is 1 exactly while some ring of thread t has a pending priority numerically below its CPPR.
- R10: Access encoding:
  - `acc_op`: 0 = read, 1 = write, 2 = pull, 3 = ignored.
  - `acc_field`: 0 = pending buffer (bits 7:0), 1 = pending priority, 2 = CPPR (bits 7:0), 3 = CAM word (bit 31 valid, bits 23:0 CAM).
  - A read or pull returns its data on `acc_rdata` with `acc_rvalid` high one cycle after the request. A write never raises `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access request |
| acc_op | input | 2 | 0 read, 1 write, 2 pull |
| acc_thread | input | $clog2(NUM_THREADS) | Thread selected |
| acc_ring | input | 2 | Ring selected (0 physical .. 3 user) |
| acc_field | input | 2 | Field selected |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read or pull data |
| acc_rvalid | output | 1 | Read data valid |
| dlv_en | input | 1 | Delivery request |
| dlv_target | input | 24 | Target identifier |
| dlv_prio | input | 3 | Priority to mark pending |
| dlv_miss | output | 1 | Delivery found no match |
| exc_out | output | NUM_THREADS | Per-thread exception |

## Verification
Read and pull data are registered, so the bench drives a request on a falling edge and samples `acc_rdata` at the next falling edge, one rising edge later. Deliveries and writes update the rings at the first rising edge. `dlv_miss` is registered, so it is checked at the falling edge that follows that rising edge. `exc_out` is combinational from the ring registers and is checked at the same falling edge. The bench also checks `dlv_miss` one cycle later to confirm the pulse lasts a single cycle.

// File: rtl/ctx_pkg.sv
// Shared constants, encodings and helpers for the thread context presenter.
// Assumes 8 priority levels and a 24-bit CAM line.
package ctx_pkg;
    localparam int NUM_RINGS    = 4;
    localparam int RING_W       = 2;
    localparam int PRIO_LVLS    = 8;
    localparam int PRIO_W       = $clog2(PRIO_LVLS);
    localparam int CAM_W        = 24;
    localparam int CHIP_W       = CAM_W - 19;
    localparam int WORD_W       = 32;
    localparam int VALID_BIT    = 31;
    localparam logic [7:0] PIPR_NONE = 8'hFF;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PULL  = 2'd2,
        OP_NONE  = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        FLD_PEND = 2'd0,
        FLD_PIPR = 2'd1,
        FLD_CPPR = 2'd2,
        FLD_CAM  = 2'd3
    } acc_fld_e;

    // Index of the lowest set bit, or PIPR_NONE for an empty buffer.
    function automatic logic [7:0] pipr_of(input logic [PRIO_LVLS-1:0] pend);
        logic [7:0] r;
        r = PIPR_NONE;
        for (int i = PRIO_LVLS - 1; i >= 0; i--) begin
            if (pend[i]) r = 8'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/ctx_ring_regs.sv
// One register ring of one thread: pending buffer, CPPR, CAM line and valid.
// Assumes the caller never asserts more than one of wr_cam and pull at once.
// For the physical ring, the CAM value is the fixed parameter FIXED_CAM.
module ctx_ring_regs
    import ctx_pkg::*;
#(
    parameter bit               IS_PHYS   = 1'b0,
    parameter logic [CAM_W-1:0] FIXED_CAM = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_pend,
    input  logic                 wr_cppr,
    input  logic                 wr_cam,
    input  logic                 pull,
    input  logic [7:0]           wr_byte,
    input  logic                 wr_valid,
    input  logic [CAM_W-1:0]     wr_cam_val,
    input  logic                 set_pend,
    input  logic [PRIO_W-1:0]    set_prio,
    output logic [PRIO_LVLS-1:0] pend_o,
    output logic [7:0]           pipr_o,
    output logic [7:0]           cppr_o,
    output logic [CAM_W-1:0]     cam_o,
    output logic                 valid_o
);
    logic [PRIO_LVLS-1:0] pend_q, pend_d, set_mask;
    logic [7:0]           cppr_q;
    logic [CAM_W-1:0]     cam_q;
    logic                 valid_q;

    // Delivery mask for the priority being marked.
    always_comb set_mask = set_pend ? (PRIO_LVLS'(1) << set_prio) : '0;

    // Next buffer: software write first, then the delivery bit on top.
    always_comb pend_d = (wr_pend ? wr_byte[PRIO_LVLS-1:0] : pend_q) | set_mask;

    // Pending buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Current processor priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cppr_q <= '0;
        else if (wr_cppr) cppr_q <= wr_byte;
    end

    // CAM valid: written by software, cleared by a pull.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= IS_PHYS;
        else if (pull)   valid_q <= 1'b0;
        else if (wr_cam) valid_q <= wr_valid;
    end

    // Software CAM value (not used by the physical ring).
    always_ff @(posedge clk) begin
        if (!rst_n)      cam_q <= '0;
        else if (wr_cam) cam_q <= wr_cam_val;
    end

    // Outputs; pending priority is purely derived.
    always_comb begin
        pend_o  = pend_q;
        pipr_o  = pipr_of(pend_q);
        cppr_o  = cppr_q;
        cam_o   = IS_PHYS ? FIXED_CAM : cam_q;
        valid_o = valid_q;
    end
endmodule

// File: rtl/ctx_cam_match.sv
// Presenter scan: compares a target with every valid CAM line.
// Lowest thread wins, then lowest ring within that thread.
module ctx_cam_match
    import ctx_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0][NUM_RINGS-1:0][CAM_W-1:0] cams,
    input  logic [NUM_THREADS-1:0][NUM_RINGS-1:0]            valids,
    input  logic [CAM_W-1:0]                                 target,
    output logic                                             hit,
    output logic [TID_W-1:0]                                 hit_thread,
    output logic [RING_W-1:0]                                hit_ring
);
    // Scan from the highest index down so the lowest match is kept last.
    always_comb begin
        hit        = 1'b0;
        hit_thread = '0;
        hit_ring   = '0;
        for (int t = NUM_THREADS - 1; t >= 0; t--) begin
            for (int r = NUM_RINGS - 1; r >= 0; r--) begin
                if (valids[t][r] && cams[t][r] == target) begin
                    hit        = 1'b1;
                    hit_thread = TID_W'(t);
                    hit_ring   = RING_W'(r);
                end
            end
        end
    end
endmodule

// File: rtl/ctx_exc_eval.sv
// Per-thread exception: any ring with pending priority below its CPPR.
module ctx_exc_eval
    import ctx_pkg::*;
(
    input  logic [NUM_RINGS-1:0][7:0] pipr,
    input  logic [NUM_RINGS-1:0][7:0] cppr,
    output logic                      exc
);
    // Reduce the ring comparisons to one exception line.
    always_comb begin
        exc = 1'b0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (pipr[r] < cppr[r]) exc = 1'b1;
        end
    end
endmodule

// File: rtl/ctx_presenter.sv
// Interrupt thread context presenter: per-thread rings, register access with
// pull, presenter CAM scan on delivery and per-thread exception outputs.
// Assumes NUM_THREADS is a power of two between 2 and 128.
module ctx_presenter
    import ctx_pkg::*;
#(
    parameter int              NUM_THREADS = 4,
    parameter logic [CHIP_W-1:0] CHIP_ID   = 5'd3,
    localparam int             TID_W       = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    input  logic [1:0]             acc_op,
    input  logic [TID_W-1:0]       acc_thread,
    input  logic [RING_W-1:0]      acc_ring,
    input  logic [1:0]             acc_field,
    input  logic [WORD_W-1:0]      acc_wdata,
    output logic [WORD_W-1:0]      acc_rdata,
    output logic                   acc_rvalid,
    input  logic                   dlv_en,
    input  logic [CAM_W-1:0]       dlv_target,
    input  logic [PRIO_W-1:0]      dlv_prio,
    output logic                   dlv_miss,
    output logic [NUM_THREADS-1:0] exc_out
);
    logic [NUM_THREADS-1:0][NUM_RINGS-1:0][PRIO_LVLS-1:0] pend_a;
    logic [NUM_THREADS-1:0][NUM_RINGS-1:0][7:0]           pipr_a, cppr_a;
    logic [NUM_THREADS-1:0][NUM_RINGS-1:0][CAM_W-1:0]     cam_a;
    logic [NUM_THREADS-1:0][NUM_RINGS-1:0]                vld_a;
    logic              hit;
    logic [TID_W-1:0]  hit_thread;
    logic [RING_W-1:0] hit_ring;
    logic              is_wr, is_pull, is_rd;
    logic              wdata_unused;
    logic [WORD_W-1:0] rd_word;

    // Operation decode shared by all rings.
    always_comb begin
        is_wr   = acc_en && acc_op == OP_WRITE;
        is_pull = acc_en && acc_op == OP_PULL;
        is_rd   = acc_en && acc_op == OP_READ;
    end

    assign wdata_unused = ^acc_wdata[VALID_BIT-1:CAM_W];

    // Presenter scan over all CAM lines.
    ctx_cam_match #(.NUM_THREADS(NUM_THREADS)) u_match (
        .cams       (cam_a),
        .valids     (vld_a),
        .target     (dlv_target),
        .hit        (hit),
        .hit_thread (hit_thread),
        .hit_ring   (hit_ring)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
            logic sel, deliver_here;
            // Ring select and delivery steering.
            always_comb begin
                sel          = acc_thread == TID_W'(t) && acc_ring == RING_W'(r);
                deliver_here = dlv_en && hit && hit_thread == TID_W'(t)
                               && hit_ring == RING_W'(r);
            end
            ctx_ring_regs #(
                .IS_PHYS   (r == 0),
                .FIXED_CAM ({CHIP_ID, 8'h00, 4'b0001, 7'(t)})
            ) u_ring (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_pend    (is_wr && sel && acc_field == FLD_PEND),
                .wr_cppr    (is_wr && sel && acc_field == FLD_CPPR),
                .wr_cam     (is_wr && sel && acc_field == FLD_CAM),
                .pull       (is_pull && sel),
                .wr_byte    (acc_wdata[7:0]),
                .wr_valid   (acc_wdata[VALID_BIT]),
                .wr_cam_val (acc_wdata[CAM_W-1:0]),
                .set_pend   (deliver_here),
                .set_prio   (dlv_prio),
                .pend_o     (pend_a[t][r]),
                .pipr_o     (pipr_a[t][r]),
                .cppr_o     (cppr_a[t][r]),
                .cam_o      (cam_a[t][r]),
                .valid_o    (vld_a[t][r])
            );
        end
        ctx_exc_eval u_exc (
            .pipr (pipr_a[t]),
            .cppr (cppr_a[t]),
            .exc  (exc_out[t])
        );
    end

    // Read data selection for the addressed ring.
    always_comb begin
        if (is_pull || acc_field == FLD_CAM) begin
            rd_word = '0;
            rd_word[VALID_BIT]   = vld_a[acc_thread][acc_ring];
            rd_word[CAM_W-1:0]   = cam_a[acc_thread][acc_ring];
        end else begin
            unique case (acc_field)
                FLD_PEND: rd_word = WORD_W'(pend_a[acc_thread][acc_ring]);
                FLD_PIPR: rd_word = WORD_W'(pipr_a[acc_thread][acc_ring]);
                default:  rd_word = WORD_W'(cppr_a[acc_thread][acc_ring]);
            endcase
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata  <= '0;
            acc_rvalid <= 1'b0;
        end else begin
            acc_rvalid <= is_rd || is_pull;
            if (is_rd || is_pull) acc_rdata <= rd_word;
        end
    end

    // Registered no-match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) dlv_miss <= 1'b0;
        else        dlv_miss <= dlv_en && !hit;
    end
endmodule

// File: rtl/ctx_presenter_chk.sv
// Assertion checker for ctx_presenter, observing its ports only.
module ctx_presenter_chk
    import ctx_pkg::*;
#(
    parameter int                NUM_THREADS = 4,
    parameter logic [CHIP_W-1:0] CHIP_ID     = 5'd3,
    localparam int               TID_W       = $clog2(NUM_THREADS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_en,
    input logic [1:0]             acc_op,
    input logic [TID_W-1:0]       acc_thread,
    input logic [RING_W-1:0]      acc_ring,
    input logic [1:0]             acc_field,
    input logic [WORD_W-1:0]      acc_rdata,
    input logic                   acc_rvalid,
    input logic                   dlv_en,
    input logic                   dlv_miss,
    input logic [NUM_THREADS-1:0] exc_out
);
    logic              started;
    logic              prev_pull;
    logic [TID_W-1:0]  prev_thr;
    logic [RING_W-1:0] prev_ring;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) started <= rst_n;

    // Remembers the previous pull target.
    always_ff @(posedge clk) begin
        prev_pull <= rst_n && acc_en && acc_op == OP_PULL;
        prev_thr  <= acc_thread;
        prev_ring <= acc_ring;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (exc_out == '0 && !dlv_miss && !acc_rvalid)); // R1

    AST_PHYS_CAM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (started && acc_rvalid && $past(acc_ring) == 2'd0 &&
         ($past(acc_field) == FLD_CAM || $past(acc_op) == OP_PULL)) |->
        acc_rdata[CAM_W-1:0] == {CHIP_ID, 8'h00, 4'b0001, 7'($past(acc_thread))}); // R2

    AST_PIPR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (started && acc_rvalid && $past(acc_op) == OP_READ && $past(acc_field) == FLD_PIPR)
        |-> (acc_rdata < 32'd8 || acc_rdata == 32'h0000_00FF)); // R3

    AST_PULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (started && prev_pull && acc_en && acc_op == OP_READ && acc_field == FLD_CAM &&
         acc_thread == prev_thr && acc_ring == prev_ring) |=> !acc_rdata[VALID_BIT]); // R4

    AST_MISS_NEEDS_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (started && dlv_miss) |-> $past(dlv_en)); // R8

    AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (started && acc_rvalid) |->
        $past(acc_en && (acc_op == OP_READ || acc_op == OP_PULL))); // R10
endmodule

bind ctx_presenter ctx_presenter_chk #(
    .NUM_THREADS (NUM_THREADS),
    .CHIP_ID     (CHIP_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_op     (acc_op),
    .acc_thread (acc_thread),
    .acc_ring   (acc_ring),
    .acc_field  (acc_field),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .dlv_en     (dlv_en),
    .dlv_miss   (dlv_miss),
    .exc_out    (exc_out)
);

// File: tb/ctx_presenter_tb.sv
// Directed bench for ctx_presenter: one task per scenario.
module ctx_presenter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic [1:0]  acc_thread = 2'd0;
    logic [1:0]  acc_ring = 2'd0;
    logic [1:0]  acc_field = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;
    logic        dlv_en = 1'b0;
    logic [23:0] dlv_target = '0;
    logic [2:0]  dlv_prio = '0;
    logic        dlv_miss;
    logic [NT-1:0] exc_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] rd;

    ctx_presenter #(.NUM_THREADS(NT), .CHIP_ID(5'd3)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_op(acc_op),
        .acc_thread(acc_thread), .acc_ring(acc_ring), .acc_field(acc_field),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
        .dlv_en(dlv_en), .dlv_target(dlv_target), .dlv_prio(dlv_prio),
        .dlv_miss(dlv_miss), .exc_out(exc_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive on a falling edge, sample at the next one.
    task automatic access(input logic [1:0] op, input logic [1:0] thr, input logic [1:0] ring,
                          input logic [1:0] fld, input logic [31:0] wd, output logic [31:0] rdata);
        @(negedge clk);
        acc_en = 1'b1; acc_op = op; acc_thread = thr; acc_ring = ring;
        acc_field = fld; acc_wdata = wd;
        @(negedge clk);
        acc_en = 1'b0;
        rdata = acc_rdata;
    endtask

    task automatic wr(input logic [1:0] thr, input logic [1:0] ring, input logic [1:0] fld,
                      input logic [31:0] wd);
        logic [31:0] unused_rd;
        access(2'd1, thr, ring, fld, wd, unused_rd);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] thr, input logic [1:0] ring,
                          input logic [1:0] fld, input logic [31:0] exp);
        logic [31:0] v;
        access(2'd0, thr, ring, fld, 32'h0, v);
        check(req, v, exp);
    endtask

    task automatic deliver(input logic [23:0] tgt, input logic [2:0] prio, output logic miss);
        @(negedge clk);
        dlv_en = 1'b1; dlv_target = tgt; dlv_prio = prio;
        @(negedge clk);
        dlv_en = 1'b0;
        miss = dlv_miss;
    endtask

    task automatic t_reset;
        check("R1 exc after reset", 32'(exc_out), 32'h0);
        check("R1 miss after reset", 32'(dlv_miss), 32'h0);
        rd_chk("R1 pend empty", 2'd1, 2'd2, 2'd0, 32'h0);
        rd_chk("R1 cppr zero", 2'd0, 2'd3, 2'd2, 32'h0);
        rd_chk("R1 hyp cam invalid", 2'd3, 2'd1, 2'd3, 32'h0);
        rd_chk("R2 phys cam t2", 2'd2, 2'd0, 2'd3, 32'h8018_0082);
        check("R10 rvalid after read", 32'(acc_rvalid), 32'h1);
    endtask

    task automatic t_phys_cam;
        wr(2'd2, 2'd0, 2'd3, 32'h0012_3456);
        check("R10 no rvalid after write", 32'(acc_rvalid), 32'h0);
        rd_chk("R2 phys cam write keeps value", 2'd2, 2'd0, 2'd3, 32'h0018_0082);
        wr(2'd2, 2'd0, 2'd3, 32'h8000_0000);
        rd_chk("R2 phys valid restored", 2'd2, 2'd0, 2'd3, 32'h8018_0082);
    endtask

    task automatic t_pipr;
        wr(2'd0, 2'd2, 2'd0, 32'h28);
        rd_chk("R3 pipr lowest bit", 2'd0, 2'd2, 2'd1, 32'h3);
        wr(2'd0, 2'd2, 2'd1, 32'h1);
        rd_chk("R3 pipr write ignored", 2'd0, 2'd2, 2'd1, 32'h3);
        rd_chk("R3 buffer unchanged by pipr write", 2'd0, 2'd2, 2'd0, 32'h28);
        wr(2'd0, 2'd2, 2'd0, 32'h80);
        rd_chk("R3 pipr top bit", 2'd0, 2'd2, 2'd1, 32'h7);
        wr(2'd0, 2'd2, 2'd0, 32'h0);
        rd_chk("R3 pipr empty", 2'd0, 2'd2, 2'd1, 32'hFF);
    endtask

    task automatic t_deliver;
        logic m;
        wr(2'd1, 2'd2, 2'd3, 32'h8000_0ABC);
        deliver(24'h000ABC, 3'd5, m);
        check("R5 hit no miss", 32'(m), 32'h0);
        rd_chk("R5 os buffer marked", 2'd1, 2'd2, 2'd0, 32'h20);
        deliver(24'h180083, 3'd0, m);
        rd_chk("R5 phys delivery t3", 2'd3, 2'd0, 2'd0, 32'h01);
    endtask

    task automatic t_order;
        logic m;
        wr(2'd0, 2'd1, 2'd3, 32'h8000_0555);
        wr(2'd2, 2'd1, 2'd3, 32'h8000_0555);
        deliver(24'h000555, 3'd2, m);
        rd_chk("R6 lowest thread wins", 2'd0, 2'd1, 2'd0, 32'h04);
        rd_chk("R6 higher thread untouched", 2'd2, 2'd1, 2'd0, 32'h00);
        wr(2'd1, 2'd3, 2'd3, 32'h8000_0ABC);
        deliver(24'h000ABC, 3'd6, m);
        rd_chk("R6 lowest ring wins", 2'd1, 2'd2, 2'd0, 32'h60);
        rd_chk("R6 user ring untouched", 2'd1, 2'd3, 2'd0, 32'h00);
    endtask

    task automatic t_miss;
        logic m;
        wr(2'd2, 2'd3, 2'd3, 32'h0000_0777);
        deliver(24'h000777, 3'd4, m);
        check("R8 miss pulse", 32'(m), 32'h1);
        @(negedge clk);
        check("R8 miss one cycle", 32'(dlv_miss), 32'h0);
        rd_chk("R7 invalid line not marked", 2'd2, 2'd3, 2'd0, 32'h00);
    endtask

    task automatic t_pull;
        logic [31:0] v;
        logic m;
        access(2'd2, 2'd0, 2'd1, 2'd0, 32'h0, v);
        check("R4 pull returns cam word", v, 32'h8000_0555);
        rd_chk("R4 pull cleared valid", 2'd0, 2'd1, 2'd3, 32'h0000_0555);
        deliver(24'h000555, 3'd1, m);
        rd_chk("R7 pulled line skipped", 2'd2, 2'd1, 2'd0, 32'h02);
        rd_chk("R7 pulled buffer unchanged", 2'd0, 2'd1, 2'd0, 32'h04);
    endtask

    task automatic t_exc;
        check("R9 no exc with cppr 0", 32'(exc_out), 32'h0);
        wr(2'd1, 2'd2, 2'd2, 32'h6);
        check("R9 exc t1 when pipr 5 < cppr 6", 32'(exc_out), 32'h2);
        wr(2'd1, 2'd2, 2'd2, 32'h5);
        check("R9 no exc when equal", 32'(exc_out), 32'h0);
        wr(2'd3, 2'd0, 2'd2, 32'h1);
        check("R9 exc t3 phys", 32'(exc_out), 32'h8);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phys_cam();
        t_pipr();
        t_deliver();
        t_order();
        t_miss();
        t_pull();
        t_exc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule